// File: doc/BRIEF.md
# DMA Bus Bandwidth Throttle

This block sits beside a DMA channel and bounds how much of a shared system bus the channel may take. A two-bit utilisation code sets a ceiling on bus ownership. The block enforces it by holding its request-permit output low for a fixed number of idle cycles after each bus cycle that the DMA engine owns. The four codes give ceilings of 100%, 50%, 25% and 12.5%. At the 100% setting the permit never drops, so the throttle adds no latency.

A second two-bit code bounds how long a priority channel may keep the bus after a grant while it waits for its peripheral to raise a request. If the channel holds priority and the grant, and the device request stays low for the programmed number of clocks (4, 8, 16 or 32), the block pulses a wait-expired output for one clock so that the bus is released. It then starts counting again. Both codes sit in one writable control nibble and return to their defaults on a synchronous reset. A new utilisation code governs the gap that follows the next owned cycle. A gap already in progress runs to its end unchanged.

Top module: `dma_bw_throttle`

## Requirements
- R1: After a synchronous reset, req_permit is 1 and wait_expired is 0. The utilisation code is 00 (100%) and the wait code is 00 (4 clocks).
- R2: An owned cycle is a cycle in which own_cycle and req_permit are both 1. The utilisation code in cfg bits 1:0 selects how many cycles req_permit stays low after each owned cycle: 00 gives 0, 01 gives 1, 10 gives 3 and 11 gives 7. These gaps cap ownership at 100%, 50%, 25% and 12.5%.
- R3: With utilisation code 00, req_permit stays 1 even when own_cycle is held high on every cycle.
- R4: Rewriting the utilisation code during a gap leaves the length of that gap unchanged. The new code first applies to the gap after the next owned cycle.
- R5: own_cycle asserted while req_permit is 0 neither restarts nor extends the gap. With own_cycle held high, exactly one cycle in every gap+1 is owned.
- R6: The wait code in cfg bits 3:2 selects the limit: 00 gives 4, 01 gives 8, 10 gives 16 and 11 gives 32 clocks. Consider a run of consecutive cycles in which prio and bus_grant are 1 and dev_req is 0. The clock edge that ends the limit-th cycle of such a run raises wait_expired.
- R7: While prio is 0 or bus_grant is 0, wait_expired stays 0 and the wait count returns to zero.
- R8: Any cycle with dev_req equal to 1 returns the wait count to zero, so runs of device requests spaced closer than the limit never raise wait_expired.
- R9: wait_expired is high for exactly one clock, after which the count reloads. While the idle condition persists, the pulse repeats every limit clocks.
- R10: A write with cfg_we = 1 loads cfg_wdata into the control nibble at the next clock edge, with the utilisation code in bits 1:0 and the wait code in bits 3:2.
- R11: A synchronous reset in mid-operation restores both codes to 00, ends any gap and clears the wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control nibble |
| cfg_wdata | input | 4 | Control nibble: bits 1:0 utilisation code, bits 3:2 wait code |
| own_cycle | input | 1 | DMA engine performs a bus cycle this clock |
| prio | input | 1 | Active channel has priority |
| bus_grant | input | 1 | Bus is granted to the DMA engine |
| dev_req | input | 1 | Peripheral requests a transfer |
| req_permit | output | 1 | DMA engine may start a bus cycle |
| wait_expired | output | 1 | One-clock pulse: priority wait limit reached, release bus |

## Verification
req_permit is registered, so it falls in the cycle right after the edge that samples an owned cycle. It stays low for exactly the gap length and is high again on the following edge. The bench drives inputs one time unit after each rising edge and reads outputs at that same point, so each reading reflects the last edge. Gap lengths are counted as the number of such readings with the permit low. wait_expired appears after the edge that ends the limit-th idle cycle, so the bench counts edges from the first idle cycle and expects the pulse on edge number limit, then again limit edges later. A configuration write counts one edge before it takes effect, and each check samples only after that edge.

// File: rtl/dma_thr_pkg.sv
// Shared types and helpers for the DMA bandwidth throttle.
// Assumes two-bit codes for both the utilisation ceiling and the wait limit.
package dma_thr_pkg;
    localparam int CODE_W = 2;
    localparam int NCODE  = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    // Control nibble layout: wait code above utilisation code.
    typedef struct packed {
        code_t wait_code;  // bits 3:2
        code_t util_code;  // bits 1:0
    } thr_cfg_t;

    localparam int CFG_W = $bits(thr_cfg_t);
endpackage

// File: rtl/dma_thr_cfg.sv
// Control nibble register for the throttle.
// Loads the whole nibble on a write strobe; synchronous active-low reset to zero.
module dma_thr_cfg
    import dma_thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output thr_cfg_t         cfg
);
    // Hold the programmed codes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (we)
            cfg <= thr_cfg_t'(wdata);
    end

    // R10: a write is visible after the next edge.
    p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg == thr_cfg_t'($past(wdata))));
endmodule

// File: rtl/dma_thr_duty.sv
// Duty-cycle limiter: after each owned bus cycle, holds the permit low for
// 2**code - 1 cycles. The code is sampled only at an owned cycle, so a
// change applies from the next gap. Strobes seen while the permit is low
// are ignored.
module dma_thr_duty
    import dma_thr_pkg::*;
#(
    parameter int GAP_W = NCODE - 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  code_t util_code,
    input  logic  own_cycle,
    output logic  permit
);
    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] gap_len;
    logic             owned;

    // Gap length for the current code.
    always_comb gap_len = GAP_W'((1 << util_code) - 1);

    // An owned cycle needs the permit.
    always_comb owned = own_cycle && permit;

    // Permit is high exactly when no gap is running.
    always_comb permit = (gap_cnt == '0);

    // Load a gap on an owned cycle, else count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (owned)
            gap_cnt <= gap_len;
        else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
    end

    // R2: a nonzero code makes the permit drop after an owned cycle.
    p_gap_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (own_cycle && permit && util_code != '0) |=> !permit);

    // R3: at full rate the permit never drops.
    p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && util_code == '0) |=> permit);

    // R5: a running gap only counts down, whatever the strobe does.
    p_gap_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_cnt != '0) |=> (gap_cnt == GAP_W'($past(gap_cnt) - 1'b1)));
endmodule

// File: rtl/dma_thr_hold.sv
// Priority wait timer: counts cycles in which a priority channel holds the
// grant without a device request. After BASE_WAIT << code such cycles it
// pulses expired for one clock and restarts the count.
module dma_thr_hold
    import dma_thr_pkg::*;
#(
    parameter int BASE_WAIT = 4,
    parameter int WAIT_W    = $clog2(BASE_WAIT) + NCODE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  code_t wait_code,
    input  logic  prio,
    input  logic  bus_grant,
    input  logic  dev_req,
    output logic  expired
);
    logic [WAIT_W-1:0] wait_cnt;
    logic [WAIT_W-1:0] last_val;
    logic              idle;

    // Priority channel holding the bus with no device request.
    always_comb idle = prio && bus_grant && !dev_req;

    // Count value at which the limit is reached.
    always_comb last_val = WAIT_W'((BASE_WAIT << wait_code) - 1);

    // Count idle cycles; pulse and reload at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            expired  <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (!idle) begin
                wait_cnt <= '0;
            end else if (wait_cnt >= last_val) begin
                wait_cnt <= '0;
                expired  <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    // R7: no expiry unless a priority channel holds the grant.
    p_needs_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(prio && bus_grant) |=> !expired);

    // R8: a device request suppresses expiry.
    p_req_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req |=> (!expired && wait_cnt == '0));

    // R9: the pulse lasts one clock.
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/dma_bw_throttle.sv
// Top of the DMA bus bandwidth throttle: control nibble, duty limiter and
// priority wait timer. Assumes own_cycle marks bus cycles the DMA engine
// runs, and that bus_grant, prio and dev_req are synchronous to clk.
module dma_bw_throttle
    import dma_thr_pkg::*;
#(
    parameter int BASE_WAIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             own_cycle,
    input  logic             prio,
    input  logic             bus_grant,
    input  logic             dev_req,
    output logic             req_permit,
    output logic             wait_expired
);
    thr_cfg_t cfg;

    dma_thr_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dma_thr_duty u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .util_code (cfg.util_code),
        .own_cycle (own_cycle),
        .permit    (req_permit)
    );

    dma_thr_hold #(
        .BASE_WAIT (BASE_WAIT)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_code (cfg.wait_code),
        .prio      (prio),
        .bus_grant (bus_grant),
        .dev_req   (dev_req),
        .expired   (wait_expired)
    );

    // R1/R11: the cycle after reset shows the idle outputs.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_permit && !wait_expired));
endmodule

// File: tb/dma_bw_throttle_test.sv
module dma_bw_throttle_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic       own_cycle = 1'b0;
    logic       prio = 1'b0;
    logic       bus_grant = 1'b0;
    logic       dev_req = 1'b0;
    logic       req_permit;
    logic       wait_expired;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_bw_throttle uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .own_cycle    (own_cycle),
        .prio         (prio),
        .bus_grant    (bus_grant),
        .dev_req      (dev_req),
        .req_permit   (req_permit),
        .wait_expired (wait_expired)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [3:0] v);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        tick();
        cfg_we    = 1'b0;
    endtask

    // One owned cycle, then count samples with the permit low.
    task automatic gap_of(output int lows);
        own_cycle = 1'b1;
        tick();
        own_cycle = 1'b0;
        lows = 0;
        while (!req_permit && lows < 64) begin
            tick();
            lows++;
        end
    endtask

    // Edges from the start of idle until the next expiry pulse.
    task automatic edges_to_expiry(output int n, output int first_hi);
        n = 0;
        first_hi = 0;
        do begin
            tick();
            n++;
            if (n == 1) first_hi = int'(wait_expired);
        end while (!wait_expired && n < 100);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lows;
        int n;
        int hi;
        int highs;

        // R1: reset state
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 permit after reset", int'(req_permit), 1);
        chk("R1 expired after reset", int'(wait_expired), 0);
        gap_of(lows);
        chk("R1 default util code gap", lows, 0);

        // R2, R10: gap per utilisation code (bits 1:0)
        for (int c = 0; c < 4; c++) begin
            write_cfg(4'(c));
            gap_of(lows);
            chk($sformatf("R2 R10 gap for code %0d", c), lows, (1 << c) - 1);
        end

        // R3, R5: own_cycle held high, count owned cycles in 64
        for (int c = 0; c < 4; c++) begin
            write_cfg(4'(c));
            while (!req_permit) tick();
            own_cycle = 1'b1;
            highs = 0;
            for (int k = 0; k < 64; k++) begin
                if (req_permit) highs++;
                tick();
            end
            own_cycle = 1'b0;
            chk($sformatf("R3 R5 owned cycles of 64, code %0d", c), highs, 64 >> c);
        end
        while (!req_permit) tick();

        // R4: code change mid-gap
        write_cfg(4'h3);
        own_cycle = 1'b1;
        tick();
        own_cycle = 1'b0;
        lows = 0;
        while (!req_permit && lows < 64) begin
            if (lows == 2) begin
                cfg_wdata = 4'h0;
                cfg_we    = 1'b1;
            end else begin
                cfg_we = 1'b0;
            end
            tick();
            lows++;
        end
        cfg_we = 1'b0;
        chk("R4 running gap keeps old length", lows, 7);
        gap_of(lows);
        chk("R4 next gap uses new code", lows, 0);

        // R6, R9, R10: wait limit per code (bits 3:2)
        for (int c = 0; c < 4; c++) begin
            write_cfg(4'(c << 2));
            prio = 1'b1;
            bus_grant = 1'b1;
            edges_to_expiry(n, hi);
            chk($sformatf("R6 R10 edges to expiry, code %0d", c), n, 4 << c);
            edges_to_expiry(n, hi);
            chk($sformatf("R9 pulse width, code %0d", c), hi, 0);
            chk($sformatf("R9 repeat period, code %0d", c), n, 4 << c);
            bus_grant = 1'b0;
            tick();
        end

        // R7: no priority / no grant
        write_cfg(4'h0);
        hi = 0;
        prio = 1'b0;
        bus_grant = 1'b1;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (wait_expired) hi++;
        end
        prio = 1'b1;
        bus_grant = 1'b0;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (wait_expired) hi++;
        end
        chk("R7 no expiry without priority grant", hi, 0);

        // R8: device requests every third cycle
        bus_grant = 1'b1;
        hi = 0;
        for (int k = 0; k < 60; k++) begin
            dev_req = (k % 3 == 2);
            tick();
            if (wait_expired) hi++;
        end
        dev_req = 1'b0;
        chk("R8 spaced requests prevent expiry", hi, 0);
        edges_to_expiry(n, hi);
        chk("R8 count restarted after last request", n, 4);
        bus_grant = 1'b0;
        prio = 1'b0;
        tick();

        // R11: reset in mid-operation
        write_cfg(4'hF);
        own_cycle = 1'b1;
        tick();
        own_cycle = 1'b0;
        chk("R11 gap running before reset", int'(req_permit), 0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R11 permit after reset", int'(req_permit), 1);
        gap_of(lows);
        chk("R11 util code restored", lows, 0);
        prio = 1'b1;
        bus_grant = 1'b1;
        edges_to_expiry(n, hi);
        chk("R11 wait code restored", n, 4);
        prio = 1'b0;
        bus_grant = 1'b0;
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule